// File: doc/BRIEF.md
# Cache Flush and Sync Controller

This controller carries out cache maintenance commands for one processor. It works on two caches. The data cache is write-back, so a dirty line must be written out before it is dropped. The instruction cache is never written, so its lines are only invalidated. A command names a line in one of two ways: by the memory-line address it holds, or by the index of a cache entry. Address-based data flushes also go out to every other processor in the system. The controller waits until each remote processor acknowledges before it counts that flush as done. Entry-based flushes and instruction-cache flushes act only on the local caches.

Commands arrive one at a time through a valid/ready handshake. For each flush the controller reads the tag state through a lookup port. The cache answers in the cycle after the lookup. If the line is a dirty data line, the controller asks for a writeback. It then invalidates the line and, when the command calls for it, runs the broadcast. Writebacks are posted. Once a writeback request is granted the flush goes on, and the writeback counts as outstanding until its completion pulse arrives. A bounded number may be outstanding at once. A sync command holds the command port until no writeback is outstanding, then pulses its done signal.

Top module: `cache_flush_sync`

## Requirements
- R1: A command is taken when `cmd_valid` and `cmd_ready` are both high at a clock edge. `cmd_ready` is high only while no command is in progress, so a command held on the port during a flush is not taken a second time.
- R2: A flush whose lookup reports a miss, or a clean line, raises `tag_rd` for one cycle and issues no writeback. It raises `tag_inv` for one cycle only on a hit. When it is local, `cmd_ready` is low for exactly 3 cycles after acceptance.
- R3: A data flush that finds a dirty line requests a writeback to the line address the cache returned. It holds the request steady until it is granted. The grant comes before the invalidate, and the flush then keeps `cmd_ready` low for exactly 4 cycles after acceptance.
- R4: Opcode 0 (data flush by address) and opcode 1 (data purge by address) behave identically at every port.
- R5: Opcodes 0 and 1 raise `bc_req`, with `bc_addr` equal to the command address, after the local invalidate. `bc_req` stays high until each bit of `bc_ack` has pulsed at least once, and the pulses may come in different cycles. It drops in the cycle after the last acknowledge.
- R6: Opcode 2 (data flush by entry index), opcode 3 (instruction flush by entry index) and opcode 4 (instruction flush by address) never raise `bc_req`. Opcodes 2 and 3 set `tag_by_entry` during the lookup. Opcodes 0, 1 and 4 clear it.
- R7: Opcodes 3 and 4 set `tag_icache` during the lookup and never request a writeback, even when the cache reports the line dirty.
- R8: Opcode 5 (sync) pulses `sync_done` for exactly one cycle, and only once no writeback is outstanding. While any is outstanding, `sync_done` stays low and `cmd_ready` stays low. With none outstanding, `cmd_ready` is low for exactly 1 cycle.
- R9: At most `MAX_WB` writebacks are outstanding at once. While that many are outstanding, a dirty flush keeps `wb_req` low and waits until a `wb_done` pulse frees a slot.
- R10: Opcodes 6 and 7 are ignored. They are accepted, they raise no lookup, and `cmd_ready` stays high.
- R11: After reset, `cmd_ready` is high. `tag_rd`, `tag_inv`, `wb_req`, `bc_req` and `sync_done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_op | input | 3 | Opcode (0..5 defined) |
| cmd_addr | input | AW | Line address or entry index |
| tag_rd | output | 1 | Tag lookup strobe |
| tag_inv | output | 1 | Invalidate strobe for the looked-up line |
| tag_icache | output | 1 | Lookup/invalidate targets the instruction cache |
| tag_by_entry | output | 1 | `tag_key` is an entry index rather than an address |
| tag_key | output | AW | Address or index for the tag port |
| tag_hit | input | 1 | Lookup hit, valid the cycle after `tag_rd` |
| tag_dirty | input | 1 | Line dirty, valid the cycle after `tag_rd` |
| tag_line | input | AW | Line address of the looked-up entry |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | AW | Writeback line address |
| wb_gnt | input | 1 | Writeback request accepted |
| wb_done | input | 1 | One outstanding writeback finished |
| bc_req | output | 1 | Broadcast flush to remote processors |
| bc_addr | output | AW | Broadcast line address |
| bc_ack | input | NREMOTE | Per-remote acknowledge pulses |
| sync_done | output | 1 | Sync complete pulse |

## Verification
The hardest case to reach is a sync arriving while a posted writeback is still open, together with a dirty flush stalled because the writeback slots are full. From the ports these only arise when `wb_done` is held back by the environment. The bench does this by withholding completion pulses. It issues a sync behind an unfinished writeback and watches `sync_done` stay low until a single pulse drains the counter. It then fills every slot with two dirty broadcast flushes before it issues a third dirty flush and checks that its request waits for a freed slot.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

    typedef enum logic [2:0] {
        OP_DFLUSH = 3'd0,
        OP_DPURGE = 3'd1,
        OP_DENTRY = 3'd2,
        OP_IENTRY = 3'd3,
        OP_IADDR  = 3'd4,
        OP_SYNC   = 3'd5
    } cmd_op_e;

    typedef struct packed {
        logic legal;
        logic is_sync;
        logic icache;
        logic by_entry;
        logic bcast;
        logic can_wb;
    } op_attr_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOKUP,
        S_CHECK,
        S_WB,
        S_INV,
        S_BCAST,
        S_SYNC
    } state_e;

    function automatic op_attr_t decode_op(logic [2:0] op);
        op_attr_t a;
        a = '0;
        case (op)
            OP_DFLUSH, OP_DPURGE: begin
                a.legal  = 1'b1;
                a.bcast  = 1'b1;
                a.can_wb = 1'b1;
            end
            OP_DENTRY: begin
                a.legal    = 1'b1;
                a.by_entry = 1'b1;
                a.can_wb   = 1'b1;
            end
            OP_IENTRY: begin
                a.legal    = 1'b1;
                a.icache   = 1'b1;
                a.by_entry = 1'b1;
            end
            OP_IADDR: begin
                a.legal  = 1'b1;
                a.icache = 1'b1;
            end
            OP_SYNC: begin
                a.legal   = 1'b1;
                a.is_sync = 1'b1;
            end
            default: a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/cfm_wb_tracker.sv
module cfm_wb_tracker #(
    parameter int MAX_WB = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic full,
    output logic empty
);
    localparam int CW = $clog2(MAX_WB + 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= (count == '0) ? count : count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign full  = (count == CW'(MAX_WB));
    assign empty = (count == '0);

    // R9
    wb_cap_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !inc);

endmodule

// File: rtl/cfm_ack_collect.sv
module cfm_ack_collect #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         armed,
    input  logic [N-1:0] ack,
    output logic         all_done
);
    localparam logic [N-1:0] ALL = '1;

    logic [N-1:0] mask;

    assign all_done = armed && ((mask | ack) == ALL);

    always_ff @(posedge clk) begin
        if (rst || all_done) begin
            mask <= '0;
        end else if (armed) begin
            mask <= mask | ack;
        end
    end

    // R5
    mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !all_done) |=> ((mask & $past(mask)) == $past(mask)));

endmodule

// File: rtl/cache_flush_sync.sv
module cache_flush_sync
    import cfm_pkg::*;
#(
    parameter int AW      = 32,
    parameter int NREMOTE = 3,
    parameter int MAX_WB  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [2:0]         cmd_op,
    input  logic [AW-1:0]      cmd_addr,
    output logic               tag_rd,
    output logic               tag_inv,
    output logic               tag_icache,
    output logic               tag_by_entry,
    output logic [AW-1:0]      tag_key,
    input  logic               tag_hit,
    input  logic               tag_dirty,
    input  logic [AW-1:0]      tag_line,
    output logic               wb_req,
    output logic [AW-1:0]      wb_addr,
    input  logic               wb_gnt,
    input  logic               wb_done,
    output logic               bc_req,
    output logic [AW-1:0]      bc_addr,
    input  logic [NREMOTE-1:0] bc_ack,
    output logic               sync_done
);

    state_e   st, st_nx;
    op_attr_t attr_q, attr_in;
    logic [AW-1:0] key_q, line_q;
    logic hit_q;
    logic accept;
    logic wb_full, wb_empty, bc_all;

    assign attr_in   = decode_op(cmd_op);
    assign cmd_ready = (st == S_IDLE);
    assign accept    = cmd_valid && cmd_ready;

    always_comb begin
        st_nx = st;
        case (st)
            S_IDLE: if (accept && attr_in.legal)
                        st_nx = attr_in.is_sync ? S_SYNC : S_LOOKUP;
            S_LOOKUP: st_nx = S_CHECK;
            S_CHECK:  st_nx = (tag_hit && tag_dirty && attr_q.can_wb) ? S_WB : S_INV;
            S_WB:     if (wb_req && wb_gnt) st_nx = S_INV;
            S_INV:    st_nx = attr_q.bcast ? S_BCAST : S_IDLE;
            S_BCAST:  if (bc_all) st_nx = S_IDLE;
            S_SYNC:   if (wb_empty) st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            attr_q <= '0;
            key_q  <= '0;
            line_q <= '0;
            hit_q  <= 1'b0;
        end else begin
            st <= st_nx;
            if (accept) begin
                attr_q <= attr_in;
                key_q  <= cmd_addr;
            end
            if (st == S_CHECK) begin
                hit_q  <= tag_hit;
                line_q <= tag_line;
            end
        end
    end

    assign tag_rd       = (st == S_LOOKUP);
    assign tag_inv      = (st == S_INV) && hit_q;
    assign tag_icache   = attr_q.icache;
    assign tag_by_entry = attr_q.by_entry;
    assign tag_key      = key_q;
    assign wb_req       = (st == S_WB) && !wb_full;
    assign wb_addr      = line_q;
    assign bc_req       = (st == S_BCAST);
    assign bc_addr      = key_q;
    assign sync_done    = (st == S_SYNC) && wb_empty;

    cfm_wb_tracker #(.MAX_WB(MAX_WB)) u_wbt (
        .clk   (clk),
        .rst   (rst),
        .inc   (wb_req && wb_gnt),
        .dec   (wb_done),
        .full  (wb_full),
        .empty (wb_empty)
    );

    cfm_ack_collect #(.N(NREMOTE)) u_ack (
        .clk      (clk),
        .rst      (rst),
        .armed    (bc_req),
        .ack      (bc_ack),
        .all_done (bc_all)
    );

    // R1
    one_action_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tag_rd, tag_inv, wb_req, bc_req, sync_done}));

    // R7
    icache_nowb_chk: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> !tag_icache);

    // R3
    wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_gnt) |=> (wb_req && $stable(wb_addr)));

    // R5
    bc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bc_req && !bc_all) |=> (bc_req && $stable(bc_addr)));

    // R8
    sync_end_chk: assert property (@(posedge clk) disable iff (rst)
        sync_done |=> cmd_ready);

endmodule

// File: tb/cache_flush_sync_bench.sv
module cache_flush_sync_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int NR = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [2:0] cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic tag_rd, tag_inv, tag_icache, tag_by_entry;
    logic [AW-1:0] tag_key;
    logic tag_hit = 1'b0, tag_dirty = 1'b0;
    logic [AW-1:0] tag_line = '0;
    logic wb_req;
    logic [AW-1:0] wb_addr;
    logic wb_gnt = 1'b1, wb_done = 1'b0;
    logic bc_req;
    logic [AW-1:0] bc_addr;
    logic [NR-1:0] bc_ack = '0;
    logic sync_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_flush_sync #(.AW(AW), .NREMOTE(NR), .MAX_WB(2)) u_cache_flush_sync (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .tag_rd(tag_rd), .tag_inv(tag_inv),
        .tag_icache(tag_icache), .tag_by_entry(tag_by_entry), .tag_key(tag_key),
        .tag_hit(tag_hit), .tag_dirty(tag_dirty), .tag_line(tag_line),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_gnt(wb_gnt), .wb_done(wb_done),
        .bc_req(bc_req), .bc_addr(bc_addr), .bc_ack(bc_ack), .sync_done(sync_done)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int n_rd = 0, n_inv = 0, n_wb = 0, n_bc = 0, n_sync = 0;
    int wb_cyc = 0, inv_cyc = 0;
    logic [AW-1:0] seen_wb_addr = '0, seen_bc_addr = '0, seen_key = '0;
    logic seen_ic = 1'b0, seen_ent = 1'b0;
    int bc_age = 0;
    int ack_dly [NR] = '{1, 4, 2};

    // passive monitor, sampled between edges
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (tag_rd) begin
            n_rd <= n_rd + 1;
            seen_ic <= tag_icache;
            seen_ent <= tag_by_entry;
            seen_key <= tag_key;
        end
        if (tag_inv) begin n_inv <= n_inv + 1; inv_cyc <= cyc; end
        if (wb_req && wb_gnt) begin n_wb <= n_wb + 1; wb_cyc <= cyc; seen_wb_addr <= wb_addr; end
        if (bc_req) begin n_bc <= n_bc + 1; seen_bc_addr <= bc_addr; end
        if (sync_done) n_sync <= n_sync + 1;
    end

    // remote processors: each acknowledges after its own delay
    always @(negedge clk) begin
        if (bc_req) begin
            for (int i = 0; i < NR; i++) bc_ack[i] <= (bc_age == ack_dly[i]);
            bc_age <= bc_age + 1;
        end else begin
            bc_ack <= '0;
            bc_age <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle(output int busy);
        busy = 0;
        while (!cmd_ready && busy < 200) begin
            busy++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic pulse_done();
        @(negedge clk); wb_done = 1'b1;
        @(negedge clk); wb_done = 1'b0;
    endtask

    task automatic set_line(input logic h, input logic d, input logic [AW-1:0] l);
        tag_hit = h; tag_dirty = d; tag_line = l;
    endtask

    task automatic t_reset();
        chk(cmd_ready == 1'b1, "R11 ready", cmd_ready, 1);
        chk({tag_rd, tag_inv, wb_req, bc_req, sync_done} == 5'b0, "R11 outputs idle",
            {tag_rd, tag_inv, wb_req, bc_req, sync_done}, 0);
    endtask

    task automatic t_clean_entry();
        int b0, i0, w0, c0, busy;
        set_line(1'b1, 1'b0, 32'h40);
        b0 = n_rd; i0 = n_inv; w0 = n_wb; c0 = n_bc;
        issue(3'd2, 32'h7);
        wait_idle(busy);
        chk(busy == 3, "R2 clean busy", busy, 3);
        chk(n_rd - b0 == 1, "R2 one lookup", n_rd - b0, 1);
        chk(n_inv - i0 == 1, "R2 invalidate on hit", n_inv - i0, 1);
        chk(n_wb == w0, "R2 no writeback", n_wb - w0, 0);
        chk(n_bc == c0, "R6 entry not broadcast", n_bc - c0, 0);
        chk(seen_ent == 1'b1 && seen_ic == 1'b0, "R6 entry data select", {seen_ent, seen_ic}, 2);
        chk(seen_key == 32'h7, "R6 key is index", seen_key, 32'h7);
    endtask

    task automatic t_miss();
        int i0, w0, busy;
        set_line(1'b0, 1'b1, 32'h80);
        i0 = n_inv; w0 = n_wb;
        issue(3'd2, 32'h9);
        wait_idle(busy);
        chk(busy == 3, "R2 miss busy", busy, 3);
        chk(n_inv == i0, "R2 no invalidate on miss", n_inv - i0, 0);
        chk(n_wb == w0, "R2 miss no writeback", n_wb - w0, 0);
    endtask

    task automatic t_dirty_entry();
        int w0, busy;
        set_line(1'b1, 1'b1, 32'h1A0);
        w0 = n_wb;
        issue(3'd2, 32'h3);
        wait_idle(busy);
        chk(busy == 4, "R3 dirty busy", busy, 4);
        chk(n_wb - w0 == 1, "R3 one writeback", n_wb - w0, 1);
        chk(seen_wb_addr == 32'h1A0, "R3 writeback address", seen_wb_addr, 32'h1A0);
        chk(wb_cyc < inv_cyc, "R3 writeback before invalidate", wb_cyc, inv_cyc);
    endtask

    task automatic t_icache(input logic [2:0] op, input logic ent);
        int w0, c0, busy;
        set_line(1'b1, 1'b1, 32'h2C0);
        w0 = n_wb; c0 = n_bc;
        issue(op, 32'h2C0);
        wait_idle(busy);
        chk(busy == 3, "R7 icache busy", busy, 3);
        chk(n_wb == w0, "R7 icache no writeback", n_wb - w0, 0);
        chk(seen_ic == 1'b1, "R7 icache select", seen_ic, 1);
        chk(seen_ent == ent, "R6 icache key kind", seen_ent, ent);
        chk(n_bc == c0, "R6 icache not broadcast", n_bc - c0, 0);
    endtask

    task automatic t_sync_pending();
        int s0, busy;
        s0 = n_sync;
        issue(3'd5, '0);
        repeat (4) @(negedge clk);
        chk(n_sync == s0, "R8 no done while pending", n_sync - s0, 0);
        chk(cmd_ready == 1'b0, "R8 held while pending", cmd_ready, 0);
        pulse_done();
        wait_idle(busy);
        chk(n_sync - s0 == 1, "R8 single done pulse", n_sync - s0, 1);
    endtask

    task automatic t_sync_idle();
        int s0, busy;
        s0 = n_sync;
        issue(3'd5, '0);
        wait_idle(busy);
        chk(busy == 1, "R8 sync idle busy", busy, 1);
        chk(n_sync - s0 == 1, "R8 sync idle done", n_sync - s0, 1);
    endtask

    task automatic t_bcast(input logic [2:0] op, output int busy, output int bcc);
        int c0, w0;
        set_line(1'b1, 1'b1, 32'h500);
        c0 = n_bc; w0 = n_wb;
        issue(op, 32'h500);
        wait_idle(busy);
        bcc = n_bc - c0;
        chk(bcc == 5, "R5 held until last ack", bcc, 5);
        chk(seen_bc_addr == 32'h500, "R5 broadcast address", seen_bc_addr, 32'h500);
        chk(n_wb - w0 == 1, "R3 broadcast dirty writeback", n_wb - w0, 1);
        chk(seen_ent == 1'b0, "R6 address key kind", seen_ent, 0);
    endtask

    task automatic t_cap();
        int w0, busy;
        set_line(1'b1, 1'b1, 32'h640);
        w0 = n_wb;
        issue(3'd2, 32'h1);
        repeat (5) @(negedge clk);
        chk(n_wb == w0, "R9 stalled at cap", n_wb - w0, 0);
        chk(cmd_ready == 1'b0, "R9 busy at cap", cmd_ready, 0);
        pulse_done();
        wait_idle(busy);
        chk(n_wb - w0 == 1, "R9 proceeds after slot frees", n_wb - w0, 1);
        pulse_done();
        pulse_done();
    endtask

    task automatic t_illegal(input logic [2:0] op);
        int r0;
        r0 = n_rd;
        issue(op, 32'h11);
        repeat (3) begin
            chk(cmd_ready == 1'b1, "R10 stays ready", cmd_ready, 1);
            @(negedge clk);
        end
        chk(n_rd == r0, "R10 no lookup", n_rd - r0, 0);
    endtask

    task automatic t_hold_valid();
        int r0;
        set_line(1'b1, 1'b0, 32'h30);
        r0 = n_rd;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd2; cmd_addr = 32'h30;
        @(negedge clk);
        chk(cmd_ready == 1'b0, "R1 busy after accept", cmd_ready, 0);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        chk(n_rd - r0 == 1, "R1 taken once", n_rd - r0, 1);
    endtask

    initial begin
        int b0, c0, b1, c1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_clean_entry();
        t_miss();
        t_dirty_entry();
        t_icache(3'd3, 1'b1);
        t_icache(3'd4, 1'b0);
        t_sync_pending();
        t_sync_idle();
        t_bcast(3'd0, b0, c0);
        t_bcast(3'd1, b1, c1);
        chk(b0 == b1 && b0 == 9, "R4 flush and purge busy match", b1, b0);
        chk(c0 == c1, "R4 flush and purge broadcast match", c1, c0);
        t_cap();
        t_sync_idle();
        t_illegal(3'd6);
        t_illegal(3'd7);
        t_hold_valid();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule